// File: doc/BRIEF.md
# Down-Counting Timer Channel with Two Match Points

This block is a single timer channel. A 32-bit counter is loaded from a programmable reload value and counts down by one on every tick of a selectable time base: either every cycle of the system clock or only on cycles where a slow external tick-enable strobe is high. Two match values mark points inside the countdown. As the count passes each usable match point, and optionally as it reaches zero, the channel inverts its interrupt level. When the count has reached zero, the next tick restarts it from the reload value, so the channel runs periodically.

Software reaches the channel through a small register port. A 2-bit select picks one of four registers: select 0 is the current count, 1 the reload value, 2 the first match value and 3 the second match value. A write is taken on a clock edge when the write strobe is high. A read is combinational. Enable, time-base select and zero-interrupt enable come in as level inputs from a shared control register that sits outside this block. Software can rewrite the count while the channel runs. It can also start a channel whose reload value was zero just by writing a nonzero reload value.

The interrupt carries no set and clear flags. Each event inverts the output level, and the interrupt controller detects edges.

Top module: `match_timer_chan`

## Requirements
- R1: While enabled and not restarting, the count drops by exactly one on each tick. With `ctlExtClk` = 0 every system-clock edge is a tick. With `ctlExtClk` = 1 only edges where `extTick` is high are ticks.
- R2: While `ctlEnable` is low, reading select 0 (count) returns the reload value.
- R3: On the first clock edge where `ctlEnable` is high after being low, the count is loaded from the reload value. No decrement happens on that edge.
- R4: On the tick where the count becomes equal to a usable nonzero match value, `irqLevel` inverts. Events therefore occur at the larger match first and then at the smaller one.
- R5: On the tick where the count becomes zero, `irqLevel` inverts if `ctlOvfIrq` is high or if either match register (select 2 or 3) holds zero. On the next tick the count restarts from the reload value, and that restart raises no event.
- R6: While `ctlEnable` is low, the count holds and `irqLevel` does not change.
- R7: The two match registers may be written in either order with the same resulting events.
- R8: A match value that is not strictly below the reload value is treated as zero and never causes a match event of its own.
- R9: Reset clears the reload value (select 1), both match values (selects 2 and 3), the count and `irqLevel` to zero.
- R10: A write to select 0 while the channel is enabled replaces the count with the written value. The tick on that edge is dropped, and counting continues from the new value.
- R11: Two equal match values produce a single inversion, not two.
- R12: While enabled, writing a nonzero value to select 1 when the reload value was zero loads the count with that value at once. Any other reload write leaves the count alone and takes effect at the next restart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| extTick | input | 1 | External 1 MHz tick enable, one system-clock cycle wide |
| ctlEnable | input | 1 | Channel enable |
| ctlExtClk | input | 1 | Time base: 1 = external tick, 0 = every system clock |
| ctlOvfIrq | input | 1 | Raise an event when the count reaches zero |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 2 | Write select: 0 count, 1 reload, 2 match A, 3 match B |
| wrData | input | 32 | Write data |
| rdSel | input | 2 | Read select, same encoding as wrSel |
| rdData | output | 32 | Read data (combinational) |
| irqLevel | output | 1 | Interrupt level, inverted on each event |

## Verification
The hardest case to reach from the ports is the reload kick: the channel must already be running with a zero reload value, idling at zero and silently restarting to zero on every tick. The stimulus clears both the reload value and the match values while the channel is disabled, then enables it. It confirms that the count stays at zero with no interrupt activity, and only then writes a nonzero reload value. A second reload write in mid-count then checks that an ordinary reload write changes nothing until the following restart. Match points placed at, above, equal to and at zero relative to the reload value are applied in separate periods so that each event rule is seen on its own.

// File: rtl/mtc_pkg.sv
`timescale 1ns/1ps
package mtc_pkg;

  // Register select codes on the software port
  localparam int SEL_COUNT      = 0;
  localparam int SEL_RELOAD     = 1;
  localparam int SEL_MATCH_BASE = 2;

  // Strobes from control to datapath, at most one load source per edge
  typedef struct packed {
    logic loadReload;   // enable rising edge: count <- reload
    logic loadWrite;    // software count write or reload kick: count <- wrData
    logic restart;      // tick at zero: count <- reload
    logic decrement;    // ordinary tick: count <- count - 1
  } cntStrobeT;

endpackage

// File: rtl/mtc_ctrl.sv
`timescale 1ns/1ps
module mtc_ctrl
  import mtc_pkg::*;
#(
  parameter int SelW = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            ctlEnable,
  input  logic            ctlExtClk,
  input  logic            extTick,
  input  logic            wrEn,
  input  logic [SelW-1:0] wrSel,
  input  logic            wrDataNonZero,
  input  logic            reloadIsZero,
  input  logic            countIsZero,
  output cntStrobeT       strobe
);

  logic enPrev;
  logic enRise;
  logic running;
  logic tickNow;
  logic wrCount;
  logic kick;
  logic tickUsed;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) enPrev <= 1'b0;
    else       enPrev <= ctlEnable;
  end

  assign enRise  = ctlEnable & ~enPrev;
  assign running = ctlEnable & enPrev;

  // Time base select: the system clock ticks every cycle
  assign tickNow = ctlExtClk ? extTick : 1'b1;

  assign wrCount = running & wrEn & (wrSel == SelW'(SEL_COUNT));
  assign kick    = running & wrEn & (wrSel == SelW'(SEL_RELOAD))
                 & reloadIsZero & wrDataNonZero;

  // A software load on the same edge swallows the tick
  assign tickUsed = running & tickNow & ~wrCount & ~kick;

  always_comb begin
    strobe            = '0;
    strobe.loadReload = enRise;
    strobe.loadWrite  = wrCount | kick;
    strobe.restart    = tickUsed & countIsZero;
    strobe.decrement  = tickUsed & ~countIsZero;
  end

endmodule

// File: rtl/mtc_datapath.sv
`timescale 1ns/1ps
module mtc_datapath
  import mtc_pkg::*;
#(
  parameter int Width    = 32,
  parameter int NumMatch = 2,
  parameter int SelW     = 2
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  cntStrobeT                      strobe,
  input  logic                           wrEn,
  input  logic [SelW-1:0]                wrSel,
  input  logic [Width-1:0]               wrData,
  input  logic                           ovfIrqEn,
  output logic [Width-1:0]               countQ,
  output logic [Width-1:0]               reloadQ,
  output logic [NumMatch-1:0][Width-1:0] matchFlat,
  output logic                           countIsZero,
  output logic                           reloadIsZero,
  output logic                           matchHit,
  output logic                           zeroHit
);

  logic [Width-1:0]    nextDec;
  logic [NumMatch-1:0] hitVec;
  logic [NumMatch-1:0] rawZeroVec;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reloadQ <= '0;
    end else if (wrEn && wrSel == SelW'(SEL_RELOAD)) begin
      reloadQ <= wrData;
    end
  end

  assign nextDec      = countQ - Width'(1);
  assign countIsZero  = (countQ == '0);
  assign reloadIsZero = (reloadQ == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countQ <= '0;
    end else if (strobe.loadReload || strobe.restart) begin
      countQ <= reloadQ;
    end else if (strobe.loadWrite) begin
      countQ <= wrData;
    end else if (strobe.decrement) begin
      countQ <= nextDec;
    end
  end

  for (genvar i = 0; i < NumMatch; i++) begin : g_match
    logic [Width-1:0] matchReg;
    logic [Width-1:0] effMatch;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        matchReg <= '0;
      end else if (wrEn && wrSel == SelW'(SEL_MATCH_BASE + i)) begin
        matchReg <= wrData;
      end
    end

    // A match at or above reload is never reached and counts as zero
    assign effMatch      = (matchReg < reloadQ) ? matchReg : '0;
    assign hitVec[i]     = (effMatch != '0) && (nextDec == effMatch);
    assign rawZeroVec[i] = (matchReg == '0);
    assign matchFlat[i]  = matchReg;
  end

  // Evaluated against the value the count is about to take
  assign matchHit = |hitVec;
  assign zeroHit  = (nextDec == '0) && (ovfIrqEn || (|rawZeroVec));

endmodule

// File: rtl/mtc_irq.sv
`timescale 1ns/1ps
module mtc_irq (
  input  logic clk,
  input  logic rstN,
  input  logic decrement,
  input  logic matchHit,
  input  logic zeroHit,
  output logic irqLevel
);

  logic eventNow;

  // Equal matches merge into one hit, so one inversion per tick at most
  assign eventNow = decrement & (matchHit | zeroHit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         irqLevel <= 1'b0;
    else if (eventNow) irqLevel <= ~irqLevel;
  end

endmodule

// File: rtl/match_timer_chan.sv
`timescale 1ns/1ps
module match_timer_chan
  import mtc_pkg::*;
#(
  parameter int Width    = 32,
  parameter int NumMatch = 2,
  parameter int SelW     = $clog2(NumMatch + 2)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            extTick,
  input  logic            ctlEnable,
  input  logic            ctlExtClk,
  input  logic            ctlOvfIrq,
  input  logic            wrEn,
  input  logic [SelW-1:0] wrSel,
  input  logic [Width-1:0] wrData,
  input  logic [SelW-1:0] rdSel,
  output logic [Width-1:0] rdData,
  output logic            irqLevel
);

  cntStrobeT                      strobe;
  logic [Width-1:0]               countQ;
  logic [Width-1:0]               reloadQ;
  logic [NumMatch-1:0][Width-1:0] matchFlat;
  logic                           countIsZero;
  logic                           reloadIsZero;
  logic                           matchHit;
  logic                           zeroHit;

  mtc_ctrl #(.SelW(SelW)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .ctlEnable    (ctlEnable),
    .ctlExtClk    (ctlExtClk),
    .extTick      (extTick),
    .wrEn         (wrEn),
    .wrSel        (wrSel),
    .wrDataNonZero(wrData != '0),
    .reloadIsZero (reloadIsZero),
    .countIsZero  (countIsZero),
    .strobe       (strobe)
  );

  mtc_datapath #(.Width(Width), .NumMatch(NumMatch), .SelW(SelW)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .wrEn        (wrEn),
    .wrSel       (wrSel),
    .wrData      (wrData),
    .ovfIrqEn    (ctlOvfIrq),
    .countQ      (countQ),
    .reloadQ     (reloadQ),
    .matchFlat   (matchFlat),
    .countIsZero (countIsZero),
    .reloadIsZero(reloadIsZero),
    .matchHit    (matchHit),
    .zeroHit     (zeroHit)
  );

  mtc_irq u_irq (
    .clk      (clk),
    .rstN     (rstN),
    .decrement(strobe.decrement),
    .matchHit (matchHit),
    .zeroHit  (zeroHit),
    .irqLevel (irqLevel)
  );

  // The count register shows the reload value while the channel is stopped
  always_comb begin
    rdData = '0;
    if (rdSel == SelW'(SEL_COUNT)) begin
      rdData = ctlEnable ? countQ : reloadQ;
    end else if (rdSel == SelW'(SEL_RELOAD)) begin
      rdData = reloadQ;
    end
    for (int i = 0; i < NumMatch; i++) begin
      if (rdSel == SelW'(SEL_MATCH_BASE + i)) rdData = matchFlat[i];
    end
  end

endmodule

// File: rtl/mtc_chk.sv
`timescale 1ns/1ps
module mtc_chk #(
  parameter int Width = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             extTick,
  input logic             ctlEnable,
  input logic             ctlExtClk,
  input logic             wrEn,
  input logic [Width-1:0] countQ,
  input logic [Width-1:0] reloadQ,
  input logic             irqLevel
);

  AST_TICK_DECREMENT: assert property (@(posedge clk) disable iff (!rstN)
    (ctlEnable && $past(ctlEnable) && $past(rstN) && (!ctlExtClk || extTick)
     && !wrEn && countQ != '0) |=> (countQ == $past(countQ) - Width'(1))); // R1

  AST_IRQ_ON_TICK: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(irqLevel) |-> ($past(ctlEnable) && $past(!ctlExtClk || extTick))); // R4

  AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !ctlEnable |=> ($stable(countQ) && $stable(irqLevel))); // R6

  AST_RESET_STATE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (countQ == '0 && reloadQ == '0 && !irqLevel)); // R9

endmodule

bind match_timer_chan mtc_chk #(.Width(Width)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .extTick  (extTick),
  .ctlEnable(ctlEnable),
  .ctlExtClk(ctlExtClk),
  .wrEn     (wrEn),
  .countQ   (countQ),
  .reloadQ  (reloadQ),
  .irqLevel (irqLevel)
);

// File: tb/sim_match_timer_chan.sv
`timescale 1ns/1ps
module sim_match_timer_chan;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        extTick = 1'b0;
  logic        ctlEnable = 1'b0;
  logic        ctlExtClk = 1'b0;
  logic        ctlOvfIrq = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrSel = 2'd0;
  logic [31:0] wrData = 32'd0;
  logic [1:0]  rdSel = 2'd0;
  logic [31:0] rdData;
  logic        irqLevel;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  typedef struct {
    int          sel;      // -1 selects the interrupt output
    logic [31:0] exp;
    string       tag;
  } itemT;

  itemT sb[$];
  event sampleEv;

  always #2 clk = ~clk;

  match_timer_chan u0 (
    .clk(clk), .rstN(rstN), .extTick(extTick), .ctlEnable(ctlEnable),
    .ctlExtClk(ctlExtClk), .ctlOvfIrq(ctlOvfIrq), .wrEn(wrEn), .wrSel(wrSel),
    .wrData(wrData), .rdSel(rdSel), .rdData(rdData), .irqLevel(irqLevel)
  );

  // Monitor: pops the oldest expectation and compares it with the port
  always @(sampleEv) begin
    itemT it;
    logic [31:0] act;
    if (sb.size() > 0) begin
      it = sb.pop_front();
      act = (it.sel < 0) ? {31'd0, irqLevel} : rdData;
      vectors++;
      if (act !== it.exp) begin
        fails++;
        $display("FAIL %s: actual %0d expected %0d", it.tag, act, it.exp);
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expectReg(input int sel, input logic [31:0] exp, input string tag);
    itemT it;
    if (sel >= 0) rdSel = 2'(sel);
    it.sel = sel; it.exp = exp; it.tag = tag;
    sb.push_back(it);
    #0.5;
    -> sampleEv;
    #0.5;
  endtask

  task automatic expectIrq(input logic exp, input string tag);
    expectReg(-1, {31'd0, exp}, tag);
  endtask

  task automatic writeReg(input int sel, input logic [31:0] data);
    wrEn = 1'b1; wrSel = 2'(sel); wrData = data;
    step(1);
    wrEn = 1'b0;
  endtask

  task automatic tickPulse();
    extTick = 1'b1;
    step(1);
    extTick = 1'b0;
    step(3);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    step(3);
    rstN = 1'b1;
    step(1);

    // R9 reset values
    expectReg(1, 0, "R9 reload after reset");
    expectReg(2, 0, "R9 match A after reset");
    expectReg(3, 0, "R9 match B after reset");
    expectReg(0, 0, "R9 count after reset");
    expectIrq(0, "R9 irq after reset");

    // R2 stopped channel shows reload
    writeReg(1, 10);
    expectReg(0, 10, "R2 stopped count reads reload");
    writeReg(2, 7);
    writeReg(3, 3);

    // R3 / R4 / R5 first period, system clock time base
    ctlEnable = 1'b1;
    step(1);
    expectReg(0, 10, "R3 enable loads reload");
    step(2);
    expectReg(0, 8, "R1 decrement per clock");
    expectIrq(0, "R4 no event above match");
    step(1);
    expectIrq(1, "R4 larger match event");
    step(3);
    expectIrq(1, "R4 no event between matches");
    step(1);
    expectIrq(0, "R4 smaller match event");
    step(3);
    expectReg(0, 0, "R1 count reaches zero");
    expectIrq(0, "R5 no zero event without ovf");
    step(1);
    expectReg(0, 10, "R5 restart from reload");
    step(3);
    expectIrq(1, "R5 second period match event");

    // R6 freeze while stopped
    ctlEnable = 1'b0;
    step(1);
    expectReg(0, 10, "R2 stopped count reads reload");
    step(20);
    expectIrq(1, "R6 irq frozen while stopped");

    // R7 swapped match order
    writeReg(2, 3);
    writeReg(3, 7);
    ctlEnable = 1'b1;
    step(1);
    expectReg(0, 10, "R3 re-enable reloads");
    step(3);
    expectIrq(0, "R7 larger match in second register");
    step(4);
    expectIrq(1, "R7 smaller match in first register");

    // R8 matches at or above reload ignored
    ctlEnable = 1'b0;
    step(1);
    writeReg(2, 10);
    writeReg(3, 50);
    ctlEnable = 1'b1;
    step(1);
    expectIrq(1, "R8 start level");
    step(11);
    expectReg(0, 10, "R8 full period restart");
    expectIrq(1, "R8 unusable matches raise nothing");
    ctlOvfIrq = 1'b1;
    step(10);
    expectReg(0, 0, "R5 count at zero");
    expectIrq(0, "R5 ovf enabled zero event");
    step(1);
    expectIrq(0, "R5 restart raises no event");

    // R11 equal matches
    ctlEnable = 1'b0;
    ctlOvfIrq = 1'b0;
    step(1);
    writeReg(2, 5);
    writeReg(3, 5);
    ctlEnable = 1'b1;
    step(1);
    step(5);
    expectReg(0, 5, "R1 count at equal match");
    expectIrq(1, "R11 single event for equal matches");
    step(5);
    expectIrq(1, "R11 no second event");

    // R5 zero match value enables zero event
    ctlEnable = 1'b0;
    step(1);
    writeReg(3, 0);
    ctlEnable = 1'b1;
    step(1);
    step(5);
    expectIrq(0, "R4 match event before zero");
    step(5);
    expectReg(0, 0, "R5 count zero");
    expectIrq(1, "R5 zero match register gives zero event");

    // R10 count write while running
    writeReg(0, 20);
    expectReg(0, 20, "R10 count write replaces count");
    step(4);
    expectReg(0, 16, "R10 counting continues from written value");

    // R12 reload kick from zero reload
    ctlEnable = 1'b0;
    step(1);
    writeReg(1, 0);
    writeReg(2, 0);
    ctlEnable = 1'b1;
    step(1);
    step(5);
    expectReg(0, 0, "R12 idle at zero reload");
    expectIrq(1, "R12 idle raises nothing");
    writeReg(1, 8);
    expectReg(0, 8, "R12 kick loads new reload");
    step(2);
    writeReg(1, 4);
    expectReg(0, 5, "R12 nonzero-to-nonzero reload leaves count");
    step(5);
    expectReg(0, 0, "R5 count zero after kick");
    expectIrq(0, "R5 zero event from zero match");
    step(1);
    expectReg(0, 4, "R12 new reload used at restart");

    // R1 external tick time base
    ctlEnable = 1'b0;
    ctlExtClk = 1'b1;
    step(1);
    writeReg(1, 6);
    ctlEnable = 1'b1;
    step(1);
    expectReg(0, 6, "R3 enable with external time base");
    tickPulse();
    tickPulse();
    expectReg(0, 4, "R1 one decrement per external tick");
    step(10);
    expectReg(0, 4, "R1 no decrement without external tick");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule